// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-level control and status registers of a small 32-bit RISC-V core: the status word, the interrupt enable and pending words, the trap vector, the exception PC, the trap cause and the trap value. The core presents one CSR access per cycle: a 12-bit address, a 3-bit operation code, the 5-bit source field and the source register value. The block returns the old contents of the addressed register in the same cycle, and the update becomes visible on the following cycle.

The same unit turns events into control flow. A synchronous exception, an mret, or an enabled and pending interrupt raises `redirect_valid` in the same cycle. `redirect_pc` then carries the trap handler address or the return address. On the next clock edge the trap bookkeeping is written into the CSRs: the saved PC, the cause, the trap value and the stacked interrupt-enable and privilege fields. The block also tracks whether the hart runs in machine or user mode, so that mret can return to the mode held in the previous-privilege field.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset the status word (0x300) reads 0x00001800 and the privilege output is 2'b11. The enable word (0x304), trap vector (0x305), saved PC (0x341), cause (0x342) and trap value (0x343) all read zero.
- R2: `csr_op[1:0]` selects the operation: 01 writes, 10 sets bits, 11 clears bits, 00 means no access. `csr_op[2]` set replaces the operand with `csr_rs1` zero-extended to 32 bits. `csr_rdata` shows the old value in the access cycle, and the new value is read back from the next cycle.
- R3: A set or clear operation performs no write when `csr_rs1` is zero, whatever `csr_rs1_val` holds. A write operation with `csr_rs1` zero still writes.
- R4: The status word stores only the global enable (bit 3), the previous enable (bit 7) and the previous privilege (bits 12:11); all other bits read zero. A write of 00 or 11 to bits 12:11 is stored as written. A write of 01 or 10 leaves the field unchanged.
- R5: The enable word keeps only bits 3 (software), 7 (timer) and 11 (external). The pending word (0x344) shows `irq_sw`, `irq_tmr` and `irq_ext` at those bits, and writes to it have no effect.
- R6: An exception redirects to the vector base. On the next edge the saved PC takes `exc_pc`, the cause takes `{1'b0, exc_code}` and the trap value takes `exc_tval`. The previous enable takes the global enable, the global enable clears, the previous privilege takes the current mode, and the mode becomes machine.
- R7: An interrupt is taken only when the global enable and the matching enable and pending bits are all set. External has priority over software, and software over timer. The cause becomes bit 31 set with code 11, 3 or 7, the saved PC takes `next_pc`, and the trap value clears.
- R8: The trap vector stores bit 0 as the mode and bits 31:2 as the base; bit 1 always reads zero. In mode 0 every trap goes to the base. In mode 1 exceptions go to the base and interrupts go to base + 4 × code.
- R9: mret redirects to the saved PC. On the next edge the global enable takes the previous enable, the previous enable clears, the mode becomes the previous privilege, and the previous privilege becomes user (00).
- R10: In one cycle an exception outranks mret, and mret outranks an interrupt. Any taken event suppresses the CSR write of that cycle, but the old value is still returned.
- R11: An address outside the seven registers reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_op | input | 3 | Operation: bit 2 selects the immediate form, bits 1:0 select write, set or clear (00 means no access) |
| csr_addr | input | 12 | CSR address |
| csr_rs1 | input | 5 | Source register index, or the immediate in the immediate forms |
| csr_rs1_val | input | 32 | Source register value |
| csr_rdata | output | 32 | Old value of the addressed CSR |
| irq_sw | input | 1 | Software interrupt pending |
| irq_tmr | input | 1 | Timer interrupt pending |
| irq_ext | input | 1 | External interrupt pending |
| exc_valid | input | 1 | Exception request |
| exc_code | input | 5 | Exception cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_tval | input | 32 | Trap value for the exception |
| next_pc | input | 32 | Address of the next instruction not yet executed |
| mret_valid | input | 1 | mret request |
| redirect_valid | output | 1 | The fetch PC must be replaced this cycle |
| redirect_pc | output | 32 | Handler or return address |
| priv_mode | output | 2 | Current privilege mode (11 machine, 00 user) |

## Verification
The functions most likely to collide in one cycle are event handling and the CSR port. An exception can arrive while an interrupt is pending, mret can coincide with a pending interrupt that the mret itself re-enables, and an exception can arrive together with a CSR write to the saved-PC register. The bench drives each pair in one cycle. It checks that the higher-ranked event alone sets `redirect_pc` and the cause. It checks that the CSR write is dropped while its old value is still returned. After an mret, it checks that the re-enabled interrupt is taken on the very next cycle with the next PC saved.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam logic [11:0] ADDR_STATUS = 12'h300;
  localparam logic [11:0] ADDR_IE     = 12'h304;
  localparam logic [11:0] ADDR_TVEC   = 12'h305;
  localparam logic [11:0] ADDR_EPC    = 12'h341;
  localparam logic [11:0] ADDR_CAUSE  = 12'h342;
  localparam logic [11:0] ADDR_TVAL   = 12'h343;
  localparam logic [11:0] ADDR_IP     = 12'h344;

  localparam int GIE_BIT  = 3;
  localparam int PGIE_BIT = 7;
  localparam int PPRV_LO  = 11;
  localparam int PPRV_HI  = 12;

  localparam int SW_BIT  = 3;
  localparam int TMR_BIT = 7;
  localparam int EXT_BIT = 11;

  localparam int CODE_SW  = 3;
  localparam int CODE_TMR = 7;
  localparam int CODE_EXT = 11;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_WRITE = 2'b01,
    K_SET   = 2'b10,
    K_CLEAR = 2'b11
  } csr_kind_e;
endpackage

// File: rtl/mtrap_status.sv
module mtrap_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_gie,
  input  logic        wr_pgie,
  input  logic [1:0]  wr_pprv,
  input  logic        trap_en,
  input  logic        mret_en,
  output logic [31:0] rd_data,
  output logic        glb_ie,
  output logic        priv_m
);
  import mtrap_pkg::*;

  logic gie_q, gie_d, pgie_q, pgie_d, pprv_q, pprv_d, prv_q, prv_d;
  logic upd_en;

  assign upd_en = trap_en | mret_en | wr_en;

  always_comb begin
    gie_d  = gie_q;
    pgie_d = pgie_q;
    pprv_d = pprv_q;
    prv_d  = prv_q;
    if (trap_en) begin
      pgie_d = gie_q;
      gie_d  = 1'b0;
      pprv_d = prv_q;
      prv_d  = 1'b1;
    end else if (mret_en) begin
      gie_d  = pgie_q;
      pgie_d = 1'b0;
      prv_d  = pprv_q;
      pprv_d = 1'b0;
    end else if (wr_en) begin
      gie_d  = wr_gie;
      pgie_d = wr_pgie;
      if (wr_pprv == 2'b11)      pprv_d = 1'b1;
      else if (wr_pprv == 2'b00) pprv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
      pprv_q <= 1'b1;
      prv_q  <= 1'b1;
    end else if (upd_en) begin
      gie_q  <= gie_d;
      pgie_q <= pgie_d;
      pprv_q <= pprv_d;
      prv_q  <= prv_d;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[GIE_BIT]         = gie_q;
    rd_data[PGIE_BIT]        = pgie_q;
    rd_data[PPRV_HI:PPRV_LO] = {2{pprv_q}};
  end

  assign glb_ie = gie_q;
  assign priv_m = prv_q;

  // R6: trap entry stacks the enable and lands in machine mode
  a_r6_trap_stack: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |=> (!gie_q && pgie_q == $past(gie_q) && prv_q && pprv_q == $past(prv_q)));
  // R9: mret unstacks the enable and returns to the saved mode
  a_r9_mret_unstack: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_en && !trap_en) |=> (gie_q == $past(pgie_q) && !pgie_q && !pprv_q && prv_q == $past(pprv_q)));
endmodule

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb #(
  parameter int CAUSE_W = 5
) (
  input  logic [2:0]         pend,   // {ext, tmr, sw}, already masked
  output logic               hit,
  output logic [2:0]         grant,
  output logic [CAUSE_W-1:0] code
);
  import mtrap_pkg::*;

  always_comb begin
    grant = 3'b000;
    code  = '0;
    if (pend[2]) begin
      grant = 3'b100;
      code  = CAUSE_W'(CODE_EXT);
    end else if (pend[0]) begin
      grant = 3'b001;
      code  = CAUSE_W'(CODE_SW);
    end else if (pend[1]) begin
      grant = 3'b010;
      code  = CAUSE_W'(CODE_TMR);
    end
  end

  assign hit = |grant;

  // R7: at most one interrupt source is granted at a time
  always_comb begin
    if (!$isunknown(pend)) begin
      a_r7_single_grant: assert ($onehot0(grant) && (hit == (pend != 3'b000)));
    end
  end
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit #(
  parameter int          XLEN     = 32,
  parameter int          CAUSE_W  = 5,
  parameter logic [31:0] TVEC_RST = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [4:0]         csr_rs1,
  input  logic [XLEN-1:0]    csr_rs1_val,
  output logic [XLEN-1:0]    csr_rdata,
  input  logic               irq_sw,
  input  logic               irq_tmr,
  input  logic               irq_ext,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_code,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [XLEN-1:0]    exc_tval,
  input  logic [XLEN-1:0]    next_pc,
  input  logic               mret_valid,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [1:0]         priv_mode
);
  import mtrap_pkg::*;

  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  csr_kind_e         kind;
  logic [XLEN-1:0]   operand, old_val, new_val, status_rd, ip_vec, ie_vec;
  logic              csr_wr, glb_ie, priv_m;
  logic              irq_hit, irq_take, trap_en, mret_en, evt_any;
  logic [2:0]        irq_pend, irq_grant, ie_q, ie_d;
  logic [CAUSE_W-1:0] irq_code;
  logic [XLEN-1:2]   tvec_base_q, tvec_base_d;
  logic              tvec_mode_q, tvec_mode_d;
  logic [XLEN-1:0]   epc_q, epc_d, cause_q, cause_d, tval_q, tval_d;
  logic              ie_en, tvec_en, epc_en, cause_en, tval_en;
  logic              sel_status, sel_ie, sel_tvec, sel_epc, sel_cause, sel_tval;
  logic [XLEN-1:0]   tvec_base;

  // ---------------- CSR access decode ----------------
  assign kind    = csr_kind_e'(csr_op[1:0]);
  assign operand = csr_op[2] ? {{(XLEN-5){1'b0}}, csr_rs1} : csr_rs1_val;

  assign sel_status = (csr_addr == ADDR_STATUS);
  assign sel_ie     = (csr_addr == ADDR_IE);
  assign sel_tvec   = (csr_addr == ADDR_TVEC);
  assign sel_epc    = (csr_addr == ADDR_EPC);
  assign sel_cause  = (csr_addr == ADDR_CAUSE);
  assign sel_tval   = (csr_addr == ADDR_TVAL);

  always_comb begin
    ip_vec          = '0;
    ip_vec[SW_BIT]  = irq_sw;
    ip_vec[TMR_BIT] = irq_tmr;
    ip_vec[EXT_BIT] = irq_ext;
    ie_vec          = '0;
    ie_vec[SW_BIT]  = ie_q[0];
    ie_vec[TMR_BIT] = ie_q[1];
    ie_vec[EXT_BIT] = ie_q[2];
  end

  assign tvec_base = {tvec_base_q, 2'b00};

  always_comb begin
    case (csr_addr)
      ADDR_STATUS: old_val = status_rd;
      ADDR_IE:     old_val = ie_vec;
      ADDR_TVEC:   old_val = {tvec_base_q, 1'b0, tvec_mode_q};
      ADDR_EPC:    old_val = epc_q;
      ADDR_CAUSE:  old_val = cause_q;
      ADDR_TVAL:   old_val = tval_q;
      ADDR_IP:     old_val = ip_vec;
      default:     old_val = '0;
    endcase
  end

  always_comb begin
    case (kind)
      K_WRITE: new_val = operand;
      K_SET:   new_val = old_val | operand;
      K_CLEAR: new_val = old_val & ~operand;
      default: new_val = old_val;
    endcase
  end

  assign csr_rdata = old_val;

  // ---------------- event ranking ----------------
  assign irq_pend = {irq_ext, irq_tmr, irq_sw} & ie_q & {3{glb_ie}};

  mtrap_irq_arb #(.CAUSE_W(CAUSE_W)) u_arb (
    .pend  (irq_pend),
    .hit   (irq_hit),
    .grant (irq_grant),
    .code  (irq_code)
  );

  assign irq_take = irq_hit & ~exc_valid & ~mret_valid;
  assign mret_en  = mret_valid & ~exc_valid;
  assign trap_en  = exc_valid | irq_take;
  assign evt_any  = trap_en | mret_en;
  assign csr_wr   = (kind != K_NONE) && ((kind == K_WRITE) || (csr_rs1 != 5'd0)) && !evt_any;

  assign redirect_valid = evt_any;
  always_comb begin
    if (exc_valid)      redirect_pc = tvec_base;
    else if (mret_en)   redirect_pc = epc_q;
    else if (tvec_mode_q) redirect_pc = tvec_base + {{(XLEN-CAUSE_W-2){1'b0}}, irq_code, 2'b00};
    else                redirect_pc = tvec_base;
  end

  // ---------------- status word ----------------
  mtrap_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_wr & sel_status),
    .wr_gie  (new_val[GIE_BIT]),
    .wr_pgie (new_val[PGIE_BIT]),
    .wr_pprv (new_val[PPRV_HI:PPRV_LO]),
    .trap_en (trap_en),
    .mret_en (mret_en),
    .rd_data (status_rd),
    .glb_ie  (glb_ie),
    .priv_m  (priv_m)
  );

  assign priv_mode = {2{priv_m}};

  // ---------------- next state ----------------
  always_comb begin
    ie_en       = csr_wr & sel_ie;
    ie_d        = {new_val[EXT_BIT], new_val[TMR_BIT], new_val[SW_BIT]};
    tvec_en     = csr_wr & sel_tvec;
    tvec_base_d = new_val[XLEN-1:2];
    tvec_mode_d = new_val[0];
    epc_en      = trap_en | (csr_wr & sel_epc);
    cause_en    = trap_en | (csr_wr & sel_cause);
    tval_en     = trap_en | (csr_wr & sel_tval);
    if (exc_valid) begin
      epc_d   = exc_pc;
      cause_d = {1'b0, {PAD_W{1'b0}}, exc_code};
      tval_d  = exc_tval;
    end else if (irq_take) begin
      epc_d   = next_pc;
      cause_d = {1'b1, {PAD_W{1'b0}}, irq_code};
      tval_d  = '0;
    end else begin
      epc_d   = new_val;
      cause_d = new_val;
      tval_d  = new_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= '0;
      tvec_base_q <= TVEC_RST[XLEN-1:2];
      tvec_mode_q <= TVEC_RST[0];
      epc_q       <= '0;
      cause_q     <= '0;
      tval_q      <= '0;
    end else begin
      if (ie_en)    ie_q <= ie_d;
      if (tvec_en) begin
        tvec_base_q <= tvec_base_d;
        tvec_mode_q <= tvec_mode_d;
      end
      if (epc_en)   epc_q   <= epc_d;
      if (cause_en) cause_q <= cause_d;
      if (tval_en)  tval_q  <= tval_d;
    end
  end

  // R6: an exception records its own PC and a cause with bit 31 clear
  a_r6_exc_record: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (epc_q == $past(exc_pc) && !cause_q[XLEN-1]));
  // R7: an interrupt redirect happens only with the global enable set
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !exc_valid && !mret_valid) |-> status_rd[GIE_BIT]);
  // R7: a taken interrupt records bit 31 set and saves the next PC
  a_r7_irq_record: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !exc_valid && !mret_valid) |=> (cause_q[XLEN-1] && epc_q == $past(next_pc)));
  // R9: mret returns to the saved PC
  a_r9_mret_target: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_valid && !exc_valid) |-> (redirect_valid && redirect_pc == epc_q));
  // R10: an exception drops a same-cycle write to the trap value
  a_r10_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> tval_q == $past(exc_tval));
endmodule

// File: tb/mtrap_csr_unit_bench.sv
module mtrap_csr_unit_bench;
  logic        clk, rst_n;
  logic [2:0]  csr_op;
  logic [11:0] csr_addr;
  logic [4:0]  csr_rs1;
  logic [31:0] csr_rs1_val, csr_rdata;
  logic        irq_sw, irq_tmr, irq_ext, exc_valid, mret_valid, redirect_valid;
  logic [4:0]  exc_code;
  logic [31:0] exc_pc, exc_tval, next_pc, redirect_pc;
  logic [1:0]  priv_mode;
  int checks = 0, errors = 0;
  logic [31:0] v;

  localparam logic [11:0] A_ST = 12'h300, A_IE = 12'h304, A_TV = 12'h305,
    A_EPC = 12'h341, A_CA = 12'h342, A_TVAL = 12'h343, A_IP = 12'h344;

  mtrap_csr_unit u_mtrap_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr), .csr_rs1(csr_rs1),
    .csr_rs1_val(csr_rs1_val), .csr_rdata(csr_rdata), .irq_sw(irq_sw), .irq_tmr(irq_tmr),
    .irq_ext(irq_ext), .exc_valid(exc_valid), .exc_code(exc_code), .exc_pc(exc_pc),
    .exc_tval(exc_tval), .next_pc(next_pc), .mret_valid(mret_valid),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .priv_mode(priv_mode));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic csr_acc(input logic [2:0] op, input logic [11:0] a, input logic [4:0] idx,
                         input logic [31:0] val, output logic [31:0] old);
    csr_op = op; csr_addr = a; csr_rs1 = idx; csr_rs1_val = val;
    #9 old = csr_rdata;
    step();
    csr_op = 3'b000;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] val);
    csr_acc(3'b010, a, 5'd0, 32'h0, val);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] val);
    logic [31:0] dummy;
    csr_acc(3'b001, a, 5'd1, val, dummy);
  endtask

  function automatic int unsigned irq_pick(input logic [2:0] p); // {ext,tmr,sw}
    if (p[2]) return 11;
    if (p[0]) return 3;
    return 7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old, exp_v, opnd;
    rst_n = 1'b0; csr_op = 0; csr_addr = 0; csr_rs1 = 0; csr_rs1_val = 0;
    irq_sw = 0; irq_tmr = 0; irq_ext = 0; exc_valid = 0; exc_code = 0;
    exc_pc = 0; exc_tval = 0; next_pc = 0; mret_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    rd(A_ST, v);   chk("R1 status", v, 32'h0000_1800);
    rd(A_IE, v);   chk("R1 enable", v, 0);
    rd(A_TV, v);   chk("R1 tvec", v, 0);
    rd(A_EPC, v);  chk("R1 epc", v, 0);
    rd(A_CA, v);   chk("R1 cause", v, 0);
    rd(A_TVAL, v); chk("R1 tval", v, 0);
    chk("R1 priv", {30'b0, priv_mode}, 3);

    // R2 every operation against several preloads
    for (int o = 1; o < 8; o++) begin
      if (o == 4) continue;
      for (int k = 0; k < 3; k++) begin
        logic [31:0] pre;
        pre = (k == 0) ? 32'hA5A5_0F0F : (k == 1) ? 32'h0 : 32'hFFFF_FFFF;
        wr(A_TVAL, pre);
        csr_acc(3'(o), A_TVAL, 5'h15, 32'h0F0F_F0F0, old);
        chk($sformatf("R2 op%0d old", o), old, pre);
        opnd = o[2] ? 32'h15 : 32'h0F0F_F0F0;
        exp_v = (o[1:0] == 1) ? opnd : (o[1:0] == 2) ? (pre | opnd) : (pre & ~opnd);
        rd(A_TVAL, v);
        chk($sformatf("R2 op%0d new", o), v, exp_v);
      end
    end

    // R3 zero source field suppresses set/clear
    wr(A_TVAL, 32'h1234_5678);
    csr_acc(3'b010, A_TVAL, 5'd0, 32'hFFFF_FFFF, old); rd(A_TVAL, v); chk("R3 set x0", v, 32'h1234_5678);
    csr_acc(3'b011, A_TVAL, 5'd0, 32'hFFFF_FFFF, old); rd(A_TVAL, v); chk("R3 clear x0", v, 32'h1234_5678);
    csr_acc(3'b110, A_TVAL, 5'd0, 32'hFFFF_FFFF, old); rd(A_TVAL, v); chk("R3 seti 0", v, 32'h1234_5678);
    csr_acc(3'b111, A_TVAL, 5'd0, 32'hFFFF_FFFF, old); rd(A_TVAL, v); chk("R3 cleari 0", v, 32'h1234_5678);
    csr_acc(3'b001, A_TVAL, 5'd0, 32'h0BAD_F00D, old); rd(A_TVAL, v); chk("R3 write x0", v, 32'h0BAD_F00D);

    // R4 status fields and previous-privilege legality sweep
    wr(A_ST, 32'hFFFF_FFFF); rd(A_ST, v); chk("R4 status mask", v, 32'h0000_1888);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 4; w++) begin
        logic [1:0] st, exp_p;
        st = s ? 2'b11 : 2'b00;
        wr(A_ST, {19'b0, st, 11'b0});
        wr(A_ST, {19'b0, 2'(w), 11'b0});
        exp_p = (w == 1 || w == 2) ? st : 2'(w);
        rd(A_ST, v);
        chk($sformatf("R4 pprv start %0d write %0d", st, w), v, {19'b0, exp_p, 11'b0});
      end
    end

    // R5 enable mask and pending reflection
    wr(A_ST, 32'h0000_1800);
    wr(A_IE, 32'hFFFF_FFFF); rd(A_IE, v); chk("R5 enable mask", v, 32'h0000_0888);
    for (int p = 0; p < 8; p++) begin
      {irq_ext, irq_tmr, irq_sw} = 3'(p);
      wr(A_IP, 32'hFFFF_FFFF);
      rd(A_IP, v);
      chk($sformatf("R5 pending %0d", p), v, {20'b0, irq_ext, 3'b0, irq_tmr, 3'b0, irq_sw, 3'b0});
    end
    {irq_ext, irq_tmr, irq_sw} = 3'b000;

    // R11 unknown addresses
    wr(12'h7C0, 32'hFFFF_FFFF); rd(12'h7C0, v); chk("R11 unknown read", v, 0);
    wr(12'h301, 32'hFFFF_FFFF); rd(12'h301, v); chk("R11 gap read", v, 0);
    rd(A_TVAL, v); chk("R11 no side write", v, 32'h0BAD_F00D);

    // R8 mode storage
    wr(A_TV, 32'h0000_0203); rd(A_TV, v); chk("R8 tvec bit1", v, 32'h0000_0201);

    // R6 exception sweep in both vector modes
    for (int m = 0; m < 2; m++) begin
      wr(A_TV, 32'h0000_0100 | m);
      for (int c = 0; c < 16; c++) begin
        wr(A_ST, 32'h0000_1808);
        exc_valid = 1; exc_code = 5'(c); exc_pc = 32'h1000 + c * 4; exc_tval = c * 32'h11;
        #9;
        chk($sformatf("R6 redirect m%0d c%0d", m, c), {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'h100});
        step(); exc_valid = 0;
        rd(A_EPC, v);  chk("R6 epc", v, 32'h1000 + c * 4);
        rd(A_CA, v);   chk("R6 cause", v, c);
        rd(A_TVAL, v); chk("R6 tval", v, c * 32'h11);
        rd(A_ST, v);   chk("R6 status", v, 32'h0000_1880);
      end
    end

    // R7/R8 interrupt priority sweep, vectored mode
    wr(A_TV, 32'h0000_0201);
    wr(A_IE, 32'h0000_0888);
    for (int p = 1; p < 8; p++) begin
      int unsigned code;
      code = irq_pick(3'(p));
      wr(A_ST, 32'h0000_1808);
      {irq_ext, irq_tmr, irq_sw} = 3'(p); next_pc = 32'h3000 + p * 4;
      #9;
      chk($sformatf("R8 vector pend %0d", p), {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'(32'h200 + 4 * code)});
      step(); {irq_ext, irq_tmr, irq_sw} = 3'b000;
      rd(A_CA, v);   chk($sformatf("R7 cause pend %0d", p), v, 32'h8000_0000 | code);
      rd(A_EPC, v);  chk("R7 epc next", v, 32'h3000 + p * 4);
      rd(A_TVAL, v); chk("R7 tval zero", v, 0);
      rd(A_ST, v);   chk("R7 status", v, 32'h0000_1880);
    end
    // R7 gating: global enable clear, then source masked
    wr(A_ST, 32'h0000_1800);
    {irq_ext, irq_tmr, irq_sw} = 3'b111; #9;
    chk("R7 global off", {31'b0, redirect_valid}, 0);
    step(); {irq_ext, irq_tmr, irq_sw} = 3'b000;
    wr(A_IE, 32'h0000_0080); wr(A_ST, 32'h0000_1808);
    irq_ext = 1; #9;
    chk("R7 masked source", {31'b0, redirect_valid}, 0);
    step(); irq_ext = 0;
    // R8 direct mode interrupt goes to base
    wr(A_TV, 32'h0000_0200); irq_tmr = 1; #9;
    chk("R8 direct irq", {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'h200});
    step(); irq_tmr = 0;

    // R9 mret back to machine, then to user, then trap from user
    wr(A_EPC, 32'h0000_4444); wr(A_ST, 32'h0000_1880);
    mret_valid = 1; #9;
    chk("R9 mret pc", {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'h4444});
    step(); mret_valid = 0;
    rd(A_ST, v); chk("R9 status after", v, 32'h0000_0008);
    chk("R9 priv machine", {30'b0, priv_mode}, 3);
    wr(A_ST, 32'h0000_0080);
    mret_valid = 1; step(); mret_valid = 0;
    chk("R9 priv user", {30'b0, priv_mode}, 0);
    rd(A_ST, v); chk("R9 status user", v, 32'h0000_0008);
    exc_valid = 1; exc_code = 5'd8; exc_pc = 32'h50; step(); exc_valid = 0;
    chk("R6 priv after trap", {30'b0, priv_mode}, 3);
    rd(A_ST, v); chk("R6 status from user", v, 32'h0000_0080);

    // R10 same-cycle collisions
    wr(A_TV, 32'h0000_0201); wr(A_IE, 32'h0000_0888); wr(A_ST, 32'h0000_1808);
    wr(A_EPC, 32'h0000_0AAA);
    {irq_ext, irq_tmr, irq_sw} = 3'b111;
    exc_valid = 1; exc_code = 5'd2; exc_pc = 32'h700; exc_tval = 32'h77;
    csr_op = 3'b001; csr_addr = A_EPC; csr_rs1 = 5'd3; csr_rs1_val = 32'h999;
    #9;
    chk("R10 exc over irq pc", {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'h200});
    chk("R10 old on collision", csr_rdata, 32'h0000_0AAA);
    step(); exc_valid = 0; csr_op = 0; {irq_ext, irq_tmr, irq_sw} = 3'b000;
    rd(A_EPC, v); chk("R10 write dropped", v, 32'h700);
    rd(A_CA, v);  chk("R10 exc cause", v, 2);
    // mret with a pending interrupt it re-enables
    wr(A_EPC, 32'h0000_0600);
    irq_ext = 1; mret_valid = 1; #9;
    chk("R10 mret over irq", {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'h600});
    step(); mret_valid = 0; next_pc = 32'h604; #9;
    chk("R10 irq next cycle", {redirect_valid, redirect_pc[30:0]}, {1'b1, 31'h22C});
    step(); irq_ext = 0;
    rd(A_EPC, v); chk("R10 irq epc", v, 32'h604);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule